// File: doc/BRIEF.md
# LCD Power-Up Sequencer

This block takes an LCD panel from power-on to a state where it accepts pixel data. When system reset is released it holds the panel's reset pin low for a set number of milliseconds. It then releases the panel and selects it. Next it plays a fixed list of command and data bytes into a one-byte write port, stopping for millisecond waits at fixed points in the list.

The list has four parts. The first is a vendor register block, which is a parameter and is followed by a wait. The second sets the orientation byte, where a mirror input picks the X mirror. The third sets the column and row window. The last sets the pixel format. After these the sequencer wakes the panel from sleep, waits the long settling time, switches the display on and leaves the panel in memory-write mode. It then deselects the panel and raises ready.

The sequence runs once for each system reset. Bus timing and pixel traffic belong to the next block in the chain. All millisecond figures come from a clock-frequency parameter. `CLK_HZ` must be a multiple of 1000, and every wait must be at least 1 ms.

Top module: `lcd_boot_seq`

## Requirements
- R1: While rst_ni is low, and for exactly RESET_MS*CLK_HZ/1000 clock cycles after it rises, the outputs are held as follows: panel_rst_no low, cs_no high, wr_o low, ready_o low.
- R2: In the cycle after the reset hold ends, panel_rst_no goes high and cs_no goes low. The first byte is written in that same cycle. panel_rst_no then stays high until the next system reset.
- R3: Each cycle with wr_o high writes one byte. dc_o is 0 for a command and 1 for a data byte, and data_o carries the byte. Entries that have no wait after them go out in back-to-back cycles, and cs_no stays low from the first byte to the last.
- R4: The vendor block goes out first, in list order. Entry i is taken from VENDOR_SEQ bits [9i+8:9i] as {dc, byte}. The default is command FE, command EF, command B4, data 00. The block is followed by a gap of VENDOR_MS*CLK_HZ/1000 cycles, during which wr_o is low and cs_no is low.
- R5: Next comes command 0x36 and one data byte. In that byte, bit 5 = 1 (rows and columns exchanged), bit 6 = NOT mirror_x_i, bit 7 = mirror_x_i, and the other bits are 0. This gives 0x60 or 0xA0.
- R6: The window comes next. Command 0x2A is followed by data 00 00 00 COLS (default A0 = 160). Command 0x2B is followed by data 00 00 00 ROWS (default 80 = 128).
- R7: Command 0x3A and data PIX_FMT (default 05, 16 bits per pixel) go out next. They are followed by a gap of FORMAT_MS*CLK_HZ/1000 cycles.
- R8: Command 0x11 is followed by a gap of WAKE_MS*CLK_HZ/1000 cycles. Commands 0x29 and 0x2C then go out in consecutive cycles.
- R9: In the cycle after command 0x2C, cs_no goes high and ready_o goes high. Both stay there, and wr_o stays low, until the next system reset.
- R10: Pulling rst_ni low at any point aborts the sequence. After release it runs again from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| mirror_x_i | input | 1 | Mirror X option for the orientation byte |
| panel_rst_no | output | 1 | Panel reset, active low |
| cs_no | output | 1 | Panel chip select, active low |
| wr_o | output | 1 | Byte write strobe, one byte per cycle |
| dc_o | output | 1 | 0 = command, 1 = data |
| data_o | output | 8 | Byte being written, zero when wr_o is low |
| ready_o | output | 1 | Sequence complete |

## Verification
The assertions take mirror_x_i as a static strap that does not change between reset release and ready. They also take the wait parameters to be nonzero, so each timed gap ends on a millisecond tick. The bench sets mirror_x_i only while rst_ni is low. It keeps the parameters at whole milliseconds with four cycles per millisecond, so every gap is a short, exactly predictable count. The bench covers both mirror settings and one reset applied in the middle of a sequence.

// File: rtl/lcd_boot_pkg.sv
package lcd_boot_pkg;

  typedef enum logic [1:0] {
    DLY_NONE   = 2'd0,
    DLY_VENDOR = 2'd1,
    DLY_FORMAT = 2'd2,
    DLY_WAKE   = 2'd3
  } dly_e;

  typedef struct packed {
    logic       is_data;
    logic [7:0] val;
    dly_e       dly;
  } seq_ent_t;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  localparam int unsigned FIX_N = 17;

  localparam logic [7:0] OP_ORIENT  = 8'h36;
  localparam logic [7:0] OP_COLS    = 8'h2A;
  localparam logic [7:0] OP_ROWS    = 8'h2B;
  localparam logic [7:0] OP_FORMAT  = 8'h3A;
  localparam logic [7:0] OP_WAKE    = 8'h11;
  localparam logic [7:0] OP_DISP_ON = 8'h29;
  localparam logic [7:0] OP_MEM_WR  = 8'h2C;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_ms_tick.sv
module lcd_ms_tick #(
  parameter int unsigned CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [PW-1:0] PMAX = PW'(CYC - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pre_q <= '0;
    else if (clr_i || pre_q == PMAX) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == PMAX) && !clr_i;

  if (CYC > 1) begin : g_gap_chk
    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o); // R3
  end

endmodule

// File: rtl/lcd_ms_delay.sv
module lcd_ms_delay #(
  parameter int unsigned    MSW     = 7,
  parameter logic [MSW-1:0] INIT_MS = MSW'(20)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [MSW-1:0] ms_i,
  input  logic           tick_i,
  output logic           last_o
);
  logic [MSW-1:0] ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ms_q <= INIT_MS;
    else if (load_i)               ms_q <= ms_i;
    else if (tick_i && ms_q != '0) ms_q <= ms_q - 1'b1;
  end

  assign last_o = tick_i && !load_i && (ms_q == MSW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_q == '0 && !load_i) |=> ms_q == '0); // R4

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ms_q != '0); // R7

endmodule

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
  import lcd_boot_pkg::*;
#(
  parameter int unsigned            VND_N      = 4,
  parameter logic [VND_N*9-1:0]     VENDOR_SEQ = {9'h100, 9'h0B4, 9'h0EF, 9'h0FE},
  parameter logic [7:0]             COLS       = 8'hA0,
  parameter logic [7:0]             ROWS       = 8'h80,
  parameter logic [7:0]             PIX_FMT    = 8'h05,
  parameter int unsigned            IW         = 5
) (
  input  logic [IW-1:0] idx_i,
  input  logic          mirror_x_i,
  output seq_ent_t      ent_o
);

  always_comb begin
    int k;
    k = int'(idx_i);
    ent_o = '{is_data: 1'b0, val: 8'h00, dly: DLY_NONE};
    if (k < int'(VND_N)) begin
      ent_o.is_data = VENDOR_SEQ[k*9+8];
      ent_o.val     = VENDOR_SEQ[k*9 +: 8];
      if (k == int'(VND_N) - 1) ent_o.dly = DLY_VENDOR;
    end else begin
      case (k - int'(VND_N))
        0:  ent_o.val = OP_ORIENT;
        1:  begin ent_o.is_data = 1'b1; ent_o.val = {mirror_x_i, !mirror_x_i, 1'b1, 5'b0}; end
        2:  ent_o.val = OP_COLS;
        3, 4, 5: ent_o.is_data = 1'b1;
        6:  begin ent_o.is_data = 1'b1; ent_o.val = COLS; end
        7:  ent_o.val = OP_ROWS;
        8, 9, 10: ent_o.is_data = 1'b1;
        11: begin ent_o.is_data = 1'b1; ent_o.val = ROWS; end
        12: ent_o.val = OP_FORMAT;
        13: begin ent_o.is_data = 1'b1; ent_o.val = PIX_FMT; ent_o.dly = DLY_FORMAT; end
        14: begin ent_o.val = OP_WAKE; ent_o.dly = DLY_WAKE; end
        15: ent_o.val = OP_DISP_ON;
        16: ent_o.val = OP_MEM_WR;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
  import lcd_boot_pkg::*;
#(
  parameter int unsigned        CLK_HZ     = 50_000_000,
  parameter int unsigned        RESET_MS   = 20,
  parameter int unsigned        VENDOR_MS  = 20,
  parameter int unsigned        FORMAT_MS  = 10,
  parameter int unsigned        WAKE_MS    = 120,
  parameter int unsigned        VND_N      = 4,
  parameter logic [VND_N*9-1:0] VENDOR_SEQ = {9'h100, 9'h0B4, 9'h0EF, 9'h0FE},
  parameter logic [7:0]         COLS       = 8'hA0,
  parameter logic [7:0]         ROWS       = 8'h80,
  parameter logic [7:0]         PIX_FMT    = 8'h05
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mirror_x_i,
  output logic       panel_rst_no,
  output logic       cs_no,
  output logic       wr_o,
  output logic       dc_o,
  output logic [7:0] data_o,
  output logic       ready_o
);
  localparam int unsigned CYC    = CLK_HZ / 1000;
  localparam int unsigned TOT_N  = VND_N + FIX_N;
  localparam int unsigned IW     = $clog2(TOT_N);
  localparam logic [IW-1:0] LAST = IW'(TOT_N - 1);
  localparam int unsigned MAX_MS = max2(max2(RESET_MS, VENDOR_MS), max2(FORMAT_MS, WAKE_MS));
  localparam int unsigned MSW    = $clog2(MAX_MS + 1);

  st_e            st_q, st_d;
  logic [IW-1:0]  idx_q, idx_d;
  seq_ent_t       ent;
  logic           load;
  logic [MSW-1:0] load_ms;
  logic           tick, last;

  function automatic logic [MSW-1:0] dly_ms(dly_e d);
    case (d)
      DLY_VENDOR: return MSW'(VENDOR_MS);
      DLY_FORMAT: return MSW'(FORMAT_MS);
      DLY_WAKE:   return MSW'(WAKE_MS);
      default:    return '0;
    endcase
  endfunction

  lcd_seq_rom #(
    .VND_N(VND_N), .VENDOR_SEQ(VENDOR_SEQ), .COLS(COLS), .ROWS(ROWS),
    .PIX_FMT(PIX_FMT), .IW(IW)
  ) u_rom (
    .idx_i(idx_q), .mirror_x_i(mirror_x_i), .ent_o(ent)
  );

  lcd_ms_tick #(.CYC(CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .tick_o(tick)
  );

  lcd_ms_delay #(.MSW(MSW), .INIT_MS(MSW'(RESET_MS))) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .ms_i(load_ms),
    .tick_i(tick), .last_o(last)
  );

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    load    = 1'b0;
    load_ms = '0;
    wr_o    = 1'b0;
    case (st_q)
      ST_HOLD: if (last) st_d = ST_SEND;
      ST_SEND: begin
        wr_o = 1'b1;
        if (ent.dly != DLY_NONE) begin
          load    = 1'b1;
          load_ms = dly_ms(ent.dly);
          st_d    = ST_WAIT;
        end else if (idx_q == LAST) begin
          st_d = ST_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_WAIT: if (last) begin
        if (idx_q == LAST) st_d = ST_DONE;
        else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_SEND;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign panel_rst_no = (st_q != ST_HOLD);
  assign cs_no        = (st_q == ST_HOLD) || (st_q == ST_DONE);
  assign ready_o      = (st_q == ST_DONE);
  assign dc_o         = wr_o && ent.is_data;
  assign data_o       = wr_o ? ent.val : 8'h00;

  AST_CS_IDLE_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !panel_rst_no |-> (cs_no && !wr_o && !ready_o)); // R1

  AST_RST_RELEASE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_rst_no |=> panel_rst_no); // R2

  AST_WR_IN_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !cs_no); // R3

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST); // R3

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (ready_o && cs_no && !wr_o)); // R9

  AST_MIRROR_STRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(mirror_x_i)); // R5

endmodule

// File: tb/lcd_boot_seq_test.sv
`timescale 1ns/1ps
module lcd_boot_seq_test;
  localparam int unsigned CLK_HZ = 4000;
  localparam int unsigned CYC    = CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mirror = 1'b0;
  logic panel_rst_n, cs_n, wr, dc, ready;
  logic [7:0] data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lcd_boot_seq #(.CLK_HZ(CLK_HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mirror_x_i(mirror),
    .panel_rst_no(panel_rst_n), .cs_no(cs_n), .wr_o(wr), .dc_o(dc),
    .data_o(data), .ready_o(ready)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {panel_rst_n, cs_n, wr, ready}
  function automatic int pins();
    return {28'd0, panel_rst_n, cs_n, wr, ready};
  endfunction

  task automatic exp_byte(bit is_data, logic [7:0] b, string req);
    int a, e;
    step();
    a = {pins(), 7'd0, dc, data};
    e = {4'b1010, 7'd0, is_data, b};
    chk(a == e, req, "byte", a, e);
  endtask

  task automatic exp_gap(int ms, string req);
    for (int i = 0; i < ms * int'(CYC); i++) begin
      step();
      chk(pins() == 4'b1000, req, "gap", pins(), 4'b1000);
    end
  endtask

  task automatic do_reset(bit m);
    @(negedge clk);
    rst_n = 1'b0;
    mirror = m;
    #1;
    chk(pins() == 4'b0100, "R1", "in reset", pins(), 4'b0100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic run_seq(bit m);
    logic [7:0] orient;
    orient = {m, !m, 1'b1, 5'b0};
    chk(pins() == 4'b0100, "R1", "hold start", pins(), 4'b0100);
    for (int i = 1; i < 20 * int'(CYC); i++) begin
      step();
      chk(pins() == 4'b0100, "R1", "hold", pins(), 4'b0100);
    end
    exp_byte(1'b0, 8'hFE, "R2");
    exp_byte(1'b0, 8'hEF, "R4");
    exp_byte(1'b0, 8'hB4, "R4");
    exp_byte(1'b1, 8'h00, "R4");
    exp_gap(20, "R4");
    exp_byte(1'b0, 8'h36, "R5");
    exp_byte(1'b1, orient, "R5");
    exp_byte(1'b0, 8'h2A, "R6");
    for (int i = 0; i < 3; i++) exp_byte(1'b1, 8'h00, "R6");
    exp_byte(1'b1, 8'hA0, "R6");
    exp_byte(1'b0, 8'h2B, "R6");
    for (int i = 0; i < 3; i++) exp_byte(1'b1, 8'h00, "R3");
    exp_byte(1'b1, 8'h80, "R6");
    exp_byte(1'b0, 8'h3A, "R7");
    exp_byte(1'b1, 8'h05, "R7");
    exp_gap(10, "R7");
    exp_byte(1'b0, 8'h11, "R8");
    exp_gap(120, "R8");
    exp_byte(1'b0, 8'h29, "R8");
    exp_byte(1'b0, 8'h2C, "R8");
    for (int i = 0; i < 40; i++) begin
      step();
      chk(pins() == 4'b1101 && data == 8'h00, "R9", "done", pins(), 4'b1101);
    end
  endtask

  initial begin
    do_reset(1'b0);
    run_seq(1'b0);
    do_reset(1'b1);
    run_seq(1'b1);
    // R10: abort part-way through the wake gap, then a full rerun
    do_reset(1'b0);
    repeat (20 * CYC + 200) @(posedge clk);
    #1;
    chk(ready == 1'b0 && cs_n == 1'b0, "R10", "mid run", pins(), 4'b1000);
    do_reset(1'b1);
    run_seq(1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule